// File: doc/BRIEF.md
# Ancillary Timecode Packet Detector

This block watches an 8-bit parallel video stream that carries separate horizontal sync, vertical sync and data-enable signals, all on the pixel clock. On a small set of vertical-blanking lines it looks inside the horizontal blanking for a timecode ancillary packet. The packet has 23 words: a three-word flag, a header, sixteen user words and a checksum. The block checks the header and the uncomplemented modulo-256 checksum. It then unpacks the BCD hours, minutes, seconds and frames, together with six flag bits. The decoded values change together, on the same cycle as a one-cycle valid strobe.

It also turns the presence of timecode into a record trigger. A frame that carries a valid packet counts as present, and a frame without one counts as absent. The first present frame after an absent period gives a one-cycle start pulse. A run of absent frames of configurable length gives a one-cycle stop pulse. A sticky error flag records any header or checksum mismatch. The block only observes the stream: it drives no pixels.

Top module: `anc_tc_detect`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `tc_valid`, `rec_start`, `rec_stop` and `err_sticky` are 0, and every decoded field is 0.
- R2: The line count returns to 0 on a rising edge of `pix_vs` and goes up by one on each rising edge of `pix_hs`. A packet is accepted only while the count is between `FIRST_LINE` and `LAST_LINE` inclusive (11 to 14 by default). A packet on line 10 or line 15 gives no strobe and leaves the fields unchanged.
- R3: A packet begins only with the words 0x00, 0xFF, 0xFF on three consecutive clocks with `pix_de` low. If that sequence is broken, no strobe and no error result.
- R4: The three words after the flag must be 0x60, 0x60 and 0x10. On the first of them that differs, parsing stops, no strobe is given and `err_sticky` is set.
- R5: The checksum is word 22 of the packet. It must equal the 8-bit sum, with no inversion, of packet words 3 through 21 (the header and all sixteen user words). A mismatch gives no strobe, leaves the fields unchanged and sets `err_sticky`.
- R6: On a valid packet, `tc_valid` is high for exactly the one cycle after the clock edge that samples the checksum word. In that same cycle the fields take these values: `tc_frames` = {user1[1:0], user0[3:0]}, `tc_seconds` = {user3[2:0], user2[3:0]}, `tc_minutes` = {user5[2:0], user4[3:0]}, `tc_hours` = {user7[1:0], user6[3:0]}. The fields hold their value in every other cycle.
- R7: `tc_flags` bit 0 is user1[2] (drop frame), bit 1 is user1[3] (colour frame), bit 2 is user3[3] (field phase), bit 3 is user5[3], bit 4 is user7[2] and bit 5 is user7[3] (binary-group flags 0 to 2).
- R8: If `pix_de` goes high before the checksum word arrives, the partial packet is discarded. No strobe is given, no error is set and the fields do not change.
- R9: A frame is judged at the `pix_vs` rising edge that ends it. If it held a valid packet while the detector was in the absent state, `rec_start` is high for one cycle, starting in the cycle after that edge.
- R10: While in the present state, `MISS_FRAMES` consecutive judged frames without a valid packet (2 by default) give a one-cycle `rec_stop` pulse and return the detector to the absent state. A single missing frame followed by a valid one gives no stop pulse.
- R11: `err_sticky` stays set through later valid packets and is cleared only by reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_data | input | 8 | Video word |
| pix_hs | input | 1 | Horizontal sync |
| pix_vs | input | 1 | Vertical sync |
| pix_de | input | 1 | Data enable (active video) |
| tc_valid | output | 1 | One-cycle strobe: a valid packet was received |
| tc_frames | output | 6 | BCD frames {tens, units} |
| tc_seconds | output | 7 | BCD seconds {tens, units} |
| tc_minutes | output | 7 | BCD minutes {tens, units} |
| tc_hours | output | 6 | BCD hours {tens, units} |
| tc_flags | output | 6 | Drop, colour, field phase, binary-group flags 0..2 |
| rec_start | output | 1 | One-cycle record-start pulse |
| rec_stop | output | 1 | One-cycle record-stop pulse |
| err_sticky | output | 1 | Header or checksum mismatch seen since reset |

## Verification
Each input word is sampled by one register stage, so `tc_valid` and the new field values appear in the cycle right after the edge that samples the checksum word. The start and stop pulses appear in the cycle right after the edge that first sees `pix_vs` high. A line counts as armed from the cycle after its `pix_hs` edge, so the bench sends a few idle words after each sync pulse before any packet. The bench changes inputs on the falling clock edge and reads the strobe on the next falling edge, which lies inside the cycle where the strobe is due. Start and stop pulses are counted on every falling edge, so a count of exactly one shows that each pulse lasted a single cycle.

// File: rtl/anc_tc_pkg.sv
package anc_tc_pkg;
  localparam int WORD_W    = 8;
  localparam int USER_WORDS = 16;
  localparam int TIME_WORDS = 8;
  localparam int USER_IDX_W = $clog2(USER_WORDS);

  localparam logic [WORD_W-1:0] FLAG_LO  = 8'h00;
  localparam logic [WORD_W-1:0] FLAG_HI  = 8'hFF;
  localparam logic [WORD_W-1:0] HDR_ID   = 8'h60;
  localparam logic [WORD_W-1:0] HDR_SUB  = 8'h60;
  localparam logic [WORD_W-1:0] HDR_CNT  = 8'h10;

  typedef enum logic [2:0] {
    PS_SEEK,
    PS_FLAG1,
    PS_FLAG2,
    PS_ID,
    PS_SUB,
    PS_CNT,
    PS_USER,
    PS_SUM
  } parse_st_t;
endpackage

// File: rtl/anc_line_tracker.sv
module anc_line_tracker #(
  parameter int LINE_W     = 13,
  parameter int FIRST_LINE = 11,
  parameter int LAST_LINE  = 14
) (
  input  logic clk,
  input  logic rst,
  input  logic hs,
  input  logic vs,
  output logic armed,
  output logic vs_rise
);
  logic              hs_prev_q, vs_prev_q;
  logic [LINE_W-1:0] line_q;
  logic              hs_rise;

  assign hs_rise = hs & ~hs_prev_q;
  assign vs_rise = vs & ~vs_prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_prev_q <= 1'b0;
      vs_prev_q <= 1'b0;
      line_q    <= '0;
    end else begin
      hs_prev_q <= hs;
      vs_prev_q <= vs;
      if (vs_rise)      line_q <= '0;
      else if (hs_rise) line_q <= line_q + 1'b1;
    end
  end

  assign armed = (line_q >= LINE_W'(FIRST_LINE)) && (line_q <= LINE_W'(LAST_LINE));

  // R2: a frame edge restarts the line count
  p_line_restart_r2: assert property (@(posedge clk) disable iff (rst)
    vs_rise |=> (line_q == '0));
endmodule

// File: rtl/anc_pkt_parser.sv
module anc_pkt_parser
  import anc_tc_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] data,
  input  logic              de,
  input  logic              armed,
  output logic              pkt_ok,
  output logic [5:0]        frames,
  output logic [6:0]        seconds,
  output logic [6:0]        minutes,
  output logic [5:0]        hours,
  output logic [5:0]        flags,
  output logic              err
);
  parse_st_t             st_q;
  logic [USER_IDX_W-1:0] idx_q;
  logic [WORD_W-1:0]     sum_q;
  logic [3:0]            time_q [TIME_WORDS];
  logic                  take;

  // a word counts only on an armed line during blanking
  assign take = armed && !de;

  always_ff @(posedge clk) begin
    if (take && st_q == PS_USER && idx_q < USER_IDX_W'(TIME_WORDS))
      time_q[idx_q[$clog2(TIME_WORDS)-1:0]] <= data[3:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= PS_SEEK;
      idx_q   <= '0;
      sum_q   <= '0;
      pkt_ok  <= 1'b0;
      frames  <= '0;
      seconds <= '0;
      minutes <= '0;
      hours   <= '0;
      flags   <= '0;
      err     <= 1'b0;
    end else begin
      pkt_ok <= 1'b0;
      if (!armed || (de && st_q != PS_SEEK)) begin
        st_q <= PS_SEEK;
      end else if (!de) begin
        unique case (st_q)
          PS_SEEK:  if (data == FLAG_LO) st_q <= PS_FLAG1;
          PS_FLAG1: begin
            if (data == FLAG_HI)      st_q <= PS_FLAG2;
            else if (data != FLAG_LO) st_q <= PS_SEEK;
          end
          PS_FLAG2: begin
            if (data == FLAG_HI)      st_q <= PS_ID;
            else if (data == FLAG_LO) st_q <= PS_FLAG1;
            else                      st_q <= PS_SEEK;
          end
          PS_ID: begin
            if (data == HDR_ID) begin
              sum_q <= data;
              st_q  <= PS_SUB;
            end else begin
              err  <= 1'b1;
              st_q <= PS_SEEK;
            end
          end
          PS_SUB: begin
            if (data == HDR_SUB) begin
              sum_q <= sum_q + data;
              st_q  <= PS_CNT;
            end else begin
              err  <= 1'b1;
              st_q <= PS_SEEK;
            end
          end
          PS_CNT: begin
            if (data == HDR_CNT) begin
              sum_q <= sum_q + data;
              idx_q <= '0;
              st_q  <= PS_USER;
            end else begin
              err  <= 1'b1;
              st_q <= PS_SEEK;
            end
          end
          PS_USER: begin
            sum_q <= sum_q + data;
            idx_q <= idx_q + 1'b1;
            if (idx_q == USER_IDX_W'(USER_WORDS - 1)) st_q <= PS_SUM;
          end
          PS_SUM: begin
            st_q <= PS_SEEK;
            if (data == sum_q) begin
              pkt_ok  <= 1'b1;
              frames  <= {time_q[1][1:0], time_q[0]};
              seconds <= {time_q[3][2:0], time_q[2]};
              minutes <= {time_q[5][2:0], time_q[4]};
              hours   <= {time_q[7][1:0], time_q[6]};
              flags   <= {time_q[7][3], time_q[7][2], time_q[5][3],
                          time_q[3][3], time_q[1][3], time_q[1][2]};
            end else begin
              err <= 1'b1;
            end
          end
          default: st_q <= PS_SEEK;
        endcase
      end
    end
  end

  // R6: the strobe lasts a single cycle
  p_strobe_single_r6: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |=> !pkt_ok);
  // R6: fields move only together with the strobe
  p_fields_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !pkt_ok |-> ($stable(frames) && $stable(hours) && $stable(flags)));
  // R2: a strobe follows a checksum sampled on an armed line
  p_strobe_armed_r2: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |-> $past(armed));
  // R8: no packet completes on a word taken during active video
  p_strobe_blank_r8: assert property (@(posedge clk) disable iff (rst)
    pkt_ok |-> !$past(de));
  // R11: the error flag never clears outside reset
  p_err_sticky_r11: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/anc_presence.sv
module anc_presence #(
  parameter int MISS_FRAMES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic vs_rise,
  input  logic pkt_ok,
  output logic rec_start,
  output logic rec_stop
);
  localparam int MW = $clog2(MISS_FRAMES + 1);

  logic          seen_q, present_q;
  logic [MW-1:0] miss_q;
  logic          seen_now;

  // a strobe on the frame edge itself belongs to the frame that ends
  assign seen_now = seen_q | pkt_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q    <= 1'b0;
      present_q <= 1'b0;
      miss_q    <= '0;
      rec_start <= 1'b0;
      rec_stop  <= 1'b0;
    end else begin
      rec_start <= 1'b0;
      rec_stop  <= 1'b0;
      if (vs_rise) begin
        seen_q <= 1'b0;
        if (seen_now) begin
          miss_q <= '0;
          if (!present_q) begin
            present_q <= 1'b1;
            rec_start <= 1'b1;
          end
        end else if (present_q) begin
          if (miss_q == MW'(MISS_FRAMES - 1)) begin
            present_q <= 1'b0;
            rec_stop  <= 1'b1;
            miss_q    <= '0;
          end else begin
            miss_q <= miss_q + 1'b1;
          end
        end
      end else if (pkt_ok) begin
        seen_q <= 1'b1;
      end
    end
  end

  // R9: start pulse is one cycle and follows a frame edge
  p_start_single_r9: assert property (@(posedge clk) disable iff (rst)
    rec_start |=> !rec_start);
  p_start_on_edge_r9: assert property (@(posedge clk) disable iff (rst)
    rec_start |-> $past(vs_rise));
  // R10: stop pulse is one cycle and follows a frame edge
  p_stop_single_r10: assert property (@(posedge clk) disable iff (rst)
    rec_stop |=> !rec_stop);
  p_stop_on_edge_r10: assert property (@(posedge clk) disable iff (rst)
    rec_stop |-> $past(vs_rise));
endmodule

// File: rtl/anc_tc_detect.sv
module anc_tc_detect #(
  parameter int LINE_W      = 13,
  parameter int FIRST_LINE  = 11,
  parameter int LAST_LINE   = 14,
  parameter int MISS_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] pix_data,
  input  logic       pix_hs,
  input  logic       pix_vs,
  input  logic       pix_de,
  output logic       tc_valid,
  output logic [5:0] tc_frames,
  output logic [6:0] tc_seconds,
  output logic [6:0] tc_minutes,
  output logic [5:0] tc_hours,
  output logic [5:0] tc_flags,
  output logic       rec_start,
  output logic       rec_stop,
  output logic       err_sticky
);
  logic armed, vs_rise;

  anc_line_tracker #(
    .LINE_W(LINE_W), .FIRST_LINE(FIRST_LINE), .LAST_LINE(LAST_LINE)
  ) u_lines (
    .clk(clk), .rst(rst), .hs(pix_hs), .vs(pix_vs),
    .armed(armed), .vs_rise(vs_rise)
  );

  anc_pkt_parser u_parse (
    .clk(clk), .rst(rst), .data(pix_data), .de(pix_de), .armed(armed),
    .pkt_ok(tc_valid), .frames(tc_frames), .seconds(tc_seconds),
    .minutes(tc_minutes), .hours(tc_hours), .flags(tc_flags),
    .err(err_sticky)
  );

  anc_presence #(.MISS_FRAMES(MISS_FRAMES)) u_pres (
    .clk(clk), .rst(rst), .vs_rise(vs_rise), .pkt_ok(tc_valid),
    .rec_start(rec_start), .rec_stop(rec_stop)
  );

  // R10: start and stop never coincide
  p_trigger_excl_r10: assert property (@(posedge clk) disable iff (rst)
    !(rec_start && rec_stop));
endmodule

// File: tb/tb_anc_tc_detect.sv
module tb_anc_tc_detect;
  localparam int M_NONE = 0, M_GOOD = 1, M_BADSUM = 2, M_BADID = 3,
                 M_ABORT = 4, M_BREAK = 5;
  localparam logic [7:0] IDLE = 8'h10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] pix_data = IDLE;
  logic       pix_hs = 1'b0, pix_vs = 1'b0, pix_de = 1'b0;
  logic       tc_valid, rec_start, rec_stop, err_sticky;
  logic [5:0] tc_frames, tc_hours, tc_flags;
  logic [6:0] tc_seconds, tc_minutes;

  int checks = 0, errors = 0;
  int n_valid = 0, n_start = 0, n_stop = 0;
  logic [7:0] udw [16];

  anc_tc_detect dut (
    .clk(clk), .rst(rst), .pix_data(pix_data), .pix_hs(pix_hs),
    .pix_vs(pix_vs), .pix_de(pix_de), .tc_valid(tc_valid),
    .tc_frames(tc_frames), .tc_seconds(tc_seconds), .tc_minutes(tc_minutes),
    .tc_hours(tc_hours), .tc_flags(tc_flags), .rec_start(rec_start),
    .rec_stop(rec_stop), .err_sticky(err_sticky)
  );

  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (!rst) begin
      if (tc_valid)  n_valid++;
      if (rec_start) n_start++;
      if (rec_stop)  n_stop++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  task automatic check_fields(input string req, input int f, input int s,
                              input int m, input int h, input int fl);
    check_eq(req, "frames",  int'(tc_frames),  f);
    check_eq(req, "seconds", int'(tc_seconds), s);
    check_eq(req, "minutes", int'(tc_minutes), m);
    check_eq(req, "hours",   int'(tc_hours),   h);
    check_eq(req, "flags",   int'(tc_flags),   fl);
  endtask

  task automatic set_tv();
    foreach (udw[i]) udw[i] = 8'h00;
    udw[0] = 8'h05; udw[1] = 8'h01; udw[2] = 8'h03; udw[3] = 8'h02;
    udw[4] = 8'h01;
  endtask

  task automatic set_alt();
    foreach (udw[i]) udw[i] = 8'hFF;
    udw[0] = 8'h09; udw[1] = 8'h0E; udw[2] = 8'h09; udw[3] = 8'h0D;
    udw[4] = 8'h09; udw[5] = 8'h0D; udw[6] = 8'h03; udw[7] = 8'h0E;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; pix_hs = 0; pix_vs = 0; pix_de = 0; pix_data = IDLE;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic emit(input int mode, input bit exp_ok);
    logic [7:0] w [23];
    int sum = 0;
    w[0] = 8'h00; w[1] = 8'hFF; w[2] = 8'hFF;
    w[3] = 8'h60; w[4] = 8'h60; w[5] = 8'h10;
    for (int i = 0; i < 16; i++) w[6+i] = udw[i];
    for (int i = 3; i < 22; i++) sum += w[i];
    w[22] = 8'(sum);
    if (mode == M_BADSUM) w[22] = w[22] + 8'd1;
    if (mode == M_BADID)  w[3]  = 8'h61;
    if (mode == M_BREAK)  w[2]  = 8'h10;
    for (int i = 0; i < 23; i++) begin
      @(negedge clk);
      pix_data = w[i];
      if (mode == M_ABORT && i == 10) begin
        pix_de = 1'b1;
        return;
      end
    end
    @(negedge clk);
    pix_data = IDLE;
    if (exp_ok) check_eq("R6", "strobe one cycle after checksum", int'(tc_valid), 1);
  endtask

  task automatic run_frame(input int pkt_line, input int mode);
    @(negedge clk); pix_vs = 1'b1;
    @(negedge clk);
    @(negedge clk); pix_vs = 1'b0;
    @(negedge clk);
    for (int ln = 1; ln <= 16; ln++) begin
      @(negedge clk); pix_hs = 1'b1;
      @(negedge clk); pix_hs = 1'b0;
      repeat (3) @(negedge clk);
      if (ln == pkt_line)
        emit(mode, mode == M_GOOD && ln >= 11 && ln <= 14);
      repeat (6) begin
        @(negedge clk); pix_de = 1'b1; pix_data = 8'h80;
      end
      @(negedge clk); pix_de = 1'b0; pix_data = IDLE;
      @(negedge clk);
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check_eq("R1", "valid in reset", int'(tc_valid), 0);
    do_reset();
    @(negedge clk);
    check_eq("R1", "valid", int'(tc_valid), 0);
    check_eq("R1", "start", int'(rec_start), 0);
    check_eq("R1", "stop", int'(rec_stop), 0);
    check_eq("R1", "err", int'(err_sticky), 0);
    check_fields("R1", 0, 0, 0, 0, 0);
  endtask

  task automatic test_basic();
    int v0, s0;
    do_reset();
    v0 = n_valid; s0 = n_start;
    set_tv();
    run_frame(12, M_GOOD);
    check_eq("R6", "strobe count", n_valid - v0, 1);
    check_fields("R6", 'h15, 'h23, 'h01, 'h00, 0);
    check_eq("R9", "no start before frame edge", n_start - s0, 0);
    run_frame(0, M_NONE);
    check_eq("R9", "start pulses", n_start - s0, 1);
  endtask

  task automatic test_flags_wrap();
    int v0, s0, p0;
    v0 = n_valid; s0 = n_start; p0 = n_stop;
    set_alt();
    run_frame(11, M_GOOD);
    check_eq("R2", "line 11 accepted", n_valid - v0, 1);
    check_eq("R5", "wrapping checksum accepted, err", int'(err_sticky), 0);
    check_fields("R7", 'h29, 'h59, 'h59, 'h23, 'h3F);
    run_frame(0, M_NONE);
    check_eq("R10", "one missed frame gives no stop", n_stop - p0, 0);
    check_eq("R9", "no second start", n_start - s0, 0);
  endtask

  task automatic test_line_bounds();
    int v0;
    do_reset();
    v0 = n_valid;
    set_tv();
    run_frame(14, M_GOOD);
    check_eq("R2", "line 14 accepted", n_valid - v0, 1);
    set_alt();
    run_frame(15, M_GOOD);
    check_eq("R2", "line 15 rejected", n_valid - v0, 1);
    run_frame(10, M_GOOD);
    check_eq("R2", "line 10 rejected", n_valid - v0, 1);
    check_fields("R2", 'h15, 'h23, 'h01, 'h00, 0);
  endtask

  task automatic test_de_abort();
    int v0;
    do_reset();
    set_tv();
    run_frame(12, M_GOOD);
    v0 = n_valid;
    set_alt();
    run_frame(13, M_ABORT);
    check_eq("R8", "aborted packet strobes", n_valid - v0, 0);
    check_eq("R8", "err", int'(err_sticky), 0);
    check_fields("R8", 'h15, 'h23, 'h01, 'h00, 0);
  endtask

  task automatic test_flag_break();
    int v0;
    do_reset();
    v0 = n_valid;
    set_tv();
    run_frame(12, M_BREAK);
    check_eq("R3", "broken flag strobes", n_valid - v0, 0);
    check_eq("R3", "err", int'(err_sticky), 0);
  endtask

  task automatic test_header_err();
    int v0;
    do_reset();
    v0 = n_valid;
    set_tv();
    run_frame(12, M_BADID);
    check_eq("R4", "bad id strobes", n_valid - v0, 0);
    check_eq("R4", "err", int'(err_sticky), 1);
    run_frame(12, M_GOOD);
    check_eq("R11", "good packet after error", n_valid - v0, 1);
    check_eq("R11", "err kept", int'(err_sticky), 1);
    do_reset();
    @(negedge clk);
    check_eq("R11", "err after reset", int'(err_sticky), 0);
  endtask

  task automatic test_csum_err();
    int v0;
    do_reset();
    set_tv();
    run_frame(12, M_GOOD);
    v0 = n_valid;
    check_eq("R5", "err after good", int'(err_sticky), 0);
    set_alt();
    run_frame(12, M_BADSUM);
    check_eq("R5", "bad checksum strobes", n_valid - v0, 0);
    check_eq("R5", "err", int'(err_sticky), 1);
    check_fields("R5", 'h15, 'h23, 'h01, 'h00, 0);
  endtask

  task automatic test_stop();
    int s0, p0;
    do_reset();
    s0 = n_start; p0 = n_stop;
    set_tv();
    run_frame(13, M_GOOD);
    run_frame(0, M_NONE);
    check_eq("R9", "start pulses", n_start - s0, 1);
    run_frame(0, M_NONE);
    check_eq("R10", "stop after one miss", n_stop - p0, 0);
    run_frame(0, M_NONE);
    check_eq("R10", "stop after two misses", n_stop - p0, 1);
    run_frame(0, M_NONE);
    check_eq("R10", "no repeated stop", n_stop - p0, 1);
    check_eq("R9", "no extra start", n_start - s0, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    test_reset();
    test_basic();
    test_flags_wrap();
    test_line_bounds();
    test_de_abort();
    test_flag_break();
    test_header_err();
    test_csum_err();
    test_stop();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule